// File: doc/BRIEF.md
# Sigma-Delta Bridge Output Stage

This block turns a signed audio sample into a one-bit pulse-density stream for a differential load. It holds the latest sample, which is written whenever the load strobe is high on a master-clock edge. A first-order error-feedback modulator then makes one output decision per master-clock cycle. Each decision drives two complementary pins that sit on either side of the load. Over any window of 256 decisions with a constant sample, the fraction of high decisions on the positive pin equals (sample + 128) / 256.

The block stays powered down while the active-low reset is held. It also powers down when a free-running monitor clock sees no master-clock activity for a set number of its own cycles. In power-down both pins are pulled low without waiting for a master-clock edge, so no DC voltage can appear across the load. When the block leaves power-down, it waits two master-clock cycles with both pins low. It then restarts with a zero sample and the modulator remainder at its midpoint.

Top module: `sd_bridge_stage`

## Requirements
- R1: While `rst_n` is low, `out_p` and `out_n` are both low, and they fall as soon as `rst_n` falls, with no master-clock edge needed.
- R2: The held sample takes `sample_in` only on a master-clock edge where `load_en` is high. A change on `sample_in` while `load_en` is low does not change the output stream.
- R3: `sample_in` is read as two's complement. With a constant held sample s, any 256 consecutive decisions contain exactly s + 128 high pulses on `out_p`.
- R4: A held sample of 0x80 (-128) gives no high pulse on `out_p`. A held sample of 0x7F (+127) gives 255 high pulses in 256 decisions.
- R5: While the block runs, `out_n` is the inverse of `out_p`, and the two are never high together.
- R6: After `rst_n` rises, the first two master-clock edges leave both pins low. The third edge makes the first decision, starting from a zero sample and a midpoint remainder of 128, so the positive pin reads 1 and then 0.
- R7: A sample loaded on edge k sets the decision made on edge k+1.
- R8: If `ref_clk` sees no master-clock toggle for `STALL_LIMIT` of its own cycles, both pins go low while the master clock is still stopped.
- R9: Once the master clock runs again after a stall, the block restarts as in R6. The held sample is cleared to zero, so the stream returns to a density of 128/256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; one modulator decision per rising edge |
| rst_n | input | 1 | Active-low reset and power-down request, asynchronous |
| ref_clk | input | 1 | Free-running monitor clock used to detect a stopped master clock |
| sample_in | input | SAMPLE_W | Signed two's-complement sample |
| load_en | input | 1 | Sample write strobe, sampled on the rising edge of `mclk` |
| out_p | output | 1 | Positive bridge drive, high on a 1 decision |
| out_n | output | 1 | Negative bridge drive, high on a 0 decision |

## Verification
A sample loaded on edge k first shows on the pins just after edge k+1. The bench therefore drops the strobe on the falling edge that follows the load. It starts counting 256 decisions at the next falling edge, so every counted decision uses the new sample. After reset release, the pins are checked on the falling edges after the first, second, third and fourth rising edges, for the pattern low-low, low-low, 1/0, 0/1. The power-down forcing on a reset or a stall is checked half a cycle after `rst_n` falls, or after a delay well past the stall limit. No master-clock edge is involved in that check. Recovery after a stall is judged over a full window of 256 decisions, so the exact cycle in which the stall clears across the two clocks does not affect the result.

// File: rtl/sd_bridge_pkg.sv
package sd_bridge_pkg;

    // Power sequencing states; each step flips one bit so decoding stays clean.
    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_WAKE = 2'b01,
        PWR_RUN  = 2'b11
    } pwr_state_e;

endpackage

// File: rtl/sd_clock_monitor.sv
module sd_clock_monitor #(
    parameter int STALL_LIMIT = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mclk_tog,
    output logic stall
);
    localparam int CNT_W = $clog2(STALL_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(STALL_LIMIT);

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             stall;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       tog_edge;

    assign tog_edge = st_q.sync[2] ^ st_q.sync[1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], mclk_tog};
        if (tog_edge) begin
            st_d.cnt   = '0;
            st_d.stall = 1'b0;
        end else if (st_q.cnt == LIMIT_C) begin
            st_d.stall = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stall = st_q.stall;

    AST_TOGGLE_CLEARS_STALL: assert property (@(posedge ref_clk) disable iff (!rst_n)
        tog_edge |=> !stall); // R8

endmodule

// File: rtl/sd_power_ctrl.sv
module sd_power_ctrl
    import sd_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic run,
    output logic heartbeat
);
    typedef struct packed {
        pwr_state_e pwr;
    } pwr_regs_t;

    pwr_regs_t st_d, st_q;
    logic      pd_n;
    logic      hb_d, hb_q;

    assign pd_n = rst_n & ~stall;

    always_comb begin
        st_d = st_q;
        unique case (st_q.pwr)
            PWR_OFF:  st_d.pwr = PWR_WAKE;
            PWR_WAKE: st_d.pwr = PWR_RUN;
            PWR_RUN:  st_d.pwr = PWR_RUN;
            default:  st_d.pwr = PWR_OFF;
        endcase
        hb_d = ~hb_q;
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) st_q.pwr <= PWR_OFF;
        else       st_q     <= st_d;
    end

    // Heartbeat runs off the plain reset so a stall cannot freeze its own evidence.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hb_q <= 1'b0;
        else        hb_q <= hb_d;
    end

    assign run       = (st_q.pwr == PWR_RUN);
    assign heartbeat = hb_q;

    AST_WAKE_BEFORE_RUN: assert property (@(posedge clk) disable iff (!pd_n)
        (st_q.pwr == PWR_RUN) |-> ($past(st_q.pwr) != PWR_OFF)); // R6

endmodule

// File: rtl/sd_sample_hold.sv
module sd_sample_hold #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                load_en,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] held
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] value;
    } hold_regs_t;

    hold_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run)         st_d.value = '0;
        else if (load_en) st_d.value = sample_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held = st_q.value;

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_en) |=> $stable(held)); // R2

endmodule

// File: rtl/sd_modulator.sv
module sd_modulator #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [SAMPLE_W-1:0] held,
    output logic                dec_bit,
    output logic                dec_valid
);
    localparam int SUM_W = SAMPLE_W + 1;
    localparam logic [SAMPLE_W-1:0] MID_C      = SAMPLE_W'(1) << (SAMPLE_W - 1);
    localparam logic [SAMPLE_W-1:0] MOST_NEG_C = MID_C;

    typedef struct packed {
        logic [SAMPLE_W-1:0] acc;
        logic                bit_out;
        logic                valid;
    } mod_regs_t;

    mod_regs_t           st_d, st_q;
    logic [SAMPLE_W-1:0] offset_code;
    logic [SUM_W-1:0]    sum;

    // Adding half scale to a two's-complement code is an MSB flip.
    assign offset_code = {~held[SAMPLE_W-1], held[SAMPLE_W-2:0]};
    assign sum         = {1'b0, st_q.acc} + {1'b0, offset_code};

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.acc     = MID_C;
            st_d.bit_out = 1'b0;
            st_d.valid   = 1'b0;
        end else begin
            st_d.acc     = sum[SAMPLE_W-1:0];
            st_d.bit_out = sum[SAMPLE_W];
            st_d.valid   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc     <= MID_C;
            st_q.bit_out <= 1'b0;
            st_q.valid   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_bit   = st_q.bit_out;
    assign dec_valid = st_q.valid;

    AST_MOST_NEG_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && held == MOST_NEG_C) |=> !dec_bit); // R4

    AST_IDLE_PARKS_MIDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.acc == MID_C && !dec_valid)); // R6

    AST_FIRST_DECISION_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !dec_valid && held == '0) |=> dec_bit); // R6

endmodule

// File: rtl/sd_bridge_map.sv
module sd_bridge_map (
    input  logic run,
    input  logic stall,
    input  logic dec_bit,
    input  logic dec_valid,
    output logic out_p,
    output logic out_n
);
    logic drive_en;

    // Gating is combinational so power-down reaches the pins with no clock.
    assign drive_en = run & dec_valid & ~stall;
    assign out_p    = drive_en &  dec_bit;
    assign out_n    = drive_en & ~dec_bit;

endmodule

// File: rtl/sd_bridge_stage.sv
module sd_bridge_stage #(
    parameter int SAMPLE_W    = 8,
    parameter int STALL_LIMIT = 16
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic                ref_clk,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                load_en,
    output logic                out_p,
    output logic                out_n
);
    logic                run;
    logic                heartbeat;
    logic                stall;
    logic [SAMPLE_W-1:0] held;
    logic                dec_bit;
    logic                dec_valid;

    sd_clock_monitor #(.STALL_LIMIT(STALL_LIMIT)) u_mon (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mclk_tog (heartbeat),
        .stall    (stall)
    );

    sd_power_ctrl u_pwr (
        .clk       (mclk),
        .rst_n     (rst_n),
        .stall     (stall),
        .run       (run),
        .heartbeat (heartbeat)
    );

    sd_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk       (mclk),
        .rst_n     (rst_n),
        .run       (run),
        .load_en   (load_en),
        .sample_in (sample_in),
        .held      (held)
    );

    sd_modulator #(.SAMPLE_W(SAMPLE_W)) u_mod (
        .clk       (mclk),
        .rst_n     (rst_n),
        .run       (run),
        .held      (held),
        .dec_bit   (dec_bit),
        .dec_valid (dec_valid)
    );

    sd_bridge_map u_map (
        .run       (run),
        .stall     (stall),
        .dec_bit   (dec_bit),
        .dec_valid (dec_valid),
        .out_p     (out_p),
        .out_n     (out_n)
    );

    always @(posedge mclk) begin
        if (!rst_n) begin
            AST_RESET_PINS_LOW: assert (!out_p && !out_n); // R1
        end
    end

    AST_BRIDGE_COMPLEMENT: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && dec_valid && !stall) |-> (out_p != out_n)); // R5

    AST_STALL_PINS_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stall |-> (!out_p && !out_n)); // R8

endmodule

// File: tb/tb_sd_bridge_stage.sv
module tb_sd_bridge_stage;

    logic       mclk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       mclk_run = 1'b1;
    logic       rst_n = 1'b1;
    logic [7:0] sample_in = 8'h00;
    logic       load_en = 1'b0;
    logic       out_p, out_n;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int NVEC = 10;
    localparam logic [7:0] VEC_SAMPLE [NVEC] =
        '{8'h00, 8'h7F, 8'h80, 8'h7F, 8'h01, 8'hFF, 8'h40, 8'hC0, 8'h13, 8'hED};
    localparam int VEC_ONES [NVEC] =
        '{128, 255, 0, 255, 129, 127, 192, 64, 147, 109};

    always #2.5 if (mclk_run) mclk = ~mclk;
    always #1 ref_clk = ~ref_clk;

    sd_bridge_stage #(.SAMPLE_W(8), .STALL_LIMIT(16)) dut (
        .mclk      (mclk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .sample_in (sample_in),
        .load_en   (load_en),
        .out_p     (out_p),
        .out_n     (out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input logic ep, input logic en);
        check(out_p == ep && out_n == en, req, {out_p, out_n}, {ep, en});
    endtask

    // Counts high decisions over 256 falling edges; also tallies complement breaks.
    task automatic count_window(output int ones, output int breaks);
        ones = 0;
        breaks = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge mclk);
            if (out_p) ones++;
            if (out_p == out_n) breaks++;
        end
    endtask

    task automatic load_sample(input logic [7:0] s);
        @(negedge mclk);
        sample_in = s;
        load_en   = 1'b1;
        @(negedge mclk);
        load_en   = 1'b0;
        sample_in = ~s;
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        int ones, breaks;
        #1 rst_n = 1'b0;

        // R1: pins quiet throughout reset
        repeat (6) @(negedge mclk);
        check_pins("R1 reset", 1'b0, 1'b0);

        // R6: release and watch the wake sequence
        rst_n = 1'b1;
        @(negedge mclk); check_pins("R6 wake edge 1", 1'b0, 1'b0);
        @(negedge mclk); check_pins("R6 wake edge 2", 1'b0, 1'b0);
        @(negedge mclk); check_pins("R6 first decision", 1'b1, 1'b0);
        @(negedge mclk); check_pins("R6 second decision", 1'b0, 1'b1);

        // R3 R4 R5 R7: vector table, each window starts one edge after the load
        for (int v = 0; v < NVEC; v++) begin
            load_sample(VEC_SAMPLE[v]);
            count_window(ones, breaks);
            check(ones == VEC_ONES[v], "R3 R4 R7 density", ones, VEC_ONES[v]);
            check(breaks == 0, "R5 complement", breaks, 0);
        end

        // R2: input changes without the strobe leave the stream alone
        load_sample(8'h40);
        count_window(ones, breaks);
        check(ones == 192, "R2 loaded", ones, 192);
        @(negedge mclk);
        sample_in = 8'h80;
        count_window(ones, breaks);
        check(ones == 192, "R2 no strobe", ones, 192);

        // R8: stop the master clock while the stream is mostly high
        load_sample(8'h7F);
        while (out_p !== 1'b1) @(negedge mclk);
        check_pins("R8 before stop", 1'b1, 1'b0);
        mclk_run = 1'b0;
        #100;
        check_pins("R8 stalled", 1'b0, 1'b0);

        // R9: restart and expect the cleared sample's density
        mclk_run = 1'b1;
        repeat (30) @(negedge mclk);
        count_window(ones, breaks);
        check(ones == 128, "R9 restart density", ones, 128);
        check(breaks == 0, "R9 R5 complement", breaks, 0);

        // R1: asynchronous drop of reset mid-stream
        load_sample(8'h7F);
        while (out_p !== 1'b1) @(negedge mclk);
        rst_n = 1'b0;
        #0.5;
        check_pins("R1 async entry", 1'b0, 1'b0);
        repeat (4) @(negedge mclk);
        check_pins("R1 held", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge mclk);
        count_window(ones, breaks);
        check(ones == 128, "R6 post reset density", ones, 128);

        report();
        $finish;
    end

endmodule